// File: doc/BRIEF.md
# Profiling Cycle Counter with Tap Event Generator

This block keeps a 32-bit count of core clock cycles for profiling and timing measurement. The count runs while it is enabled and the core is not halted. Software can read the count, write a new value into it, and set a small control register through a two-address register port. The count wraps to zero after all ones.

The counter also drives an event generator. One of two counter bits is chosen as a tap. Each change of that bit, in either direction, is a tap. A reloadable 4-bit postscaler decides which taps produce an output. A qualifying tap produces one of two outputs. If program-counter sampling is enabled, the block emits a one-cycle sample pulse together with the PC value present on the tap cycle. Otherwise, if cycle events are enabled, it emits a one-cycle event pulse. Each pulse appears in the cycle after the tap, at the same time as the counter shows the value that flipped the tap bit.

Top module: `cyccnt_sampler`

## Requirements
- R1: The count increases by one on each clock edge where the count enable (control bit 0) is set and `halted` is low. Reading register address 0 returns the count.
- R2: The count holds its value on every edge where `halted` is high.
- R3: The next increment after the value 0xFFFFFFFF gives 0, and counting continues from there.
- R4: A write to address 0 loads the count on the next edge. The write replaces that cycle's increment, and no tap comes from that cycle.
- R5: The control register is at address 1. Its fields are: bit 0 count enable, bit 1 PC-sample enable, bit 2 cycle-event enable, bit 3 tap select, and bits 7:4 the postscaler reload value. A read returns these eight bits, with all higher bits zero. Higher bits of a write are ignored.
- R6: A tap occurs on an increment that changes the selected count bit, in either direction. Tap select 0 chooses bit 6 and tap select 1 chooses bit 10.
- R7: On a tap with the postscaler at zero, an output qualifies and the postscaler reloads from the reload field. On a tap with the postscaler above zero, it decrements and nothing is emitted. A control write loads the postscaler with the newly written reload value.
- R8: When the PC-sample enable is set, each qualifying tap raises `sample_valid` for one cycle, on the cycle after the tap. `sample_pc` then holds the `pc_in` value from the tap cycle. No event pulse is raised, even if the cycle-event enable is also set.
- R9: When the cycle-event enable is set and the PC-sample enable is clear, each qualifying tap raises `event_pulse` for one cycle, on the cycle after the tap.
- R10: When both output enables are clear, no pulse is produced. The postscaler still moves on taps.
- R11: After reset, the count, the control register and the postscaler are zero, and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halted | input | 1 | Core halted; freezes the count |
| pc_in | input | 32 | Current program counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 count, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| sample_valid | output | 1 | One-cycle PC sample pulse |
| sample_pc | output | 32 | PC captured with the last sample |
| event_pulse | output | 1 | One-cycle cycle-event pulse |

## Verification
From reset, it would take 1024 cycles to reach a change of bit 10, and about four billion cycles to reach a wrap. Postscaler behaviour needs several taps in a row. The stimulus gets to these cases by writing count values just below each tap edge and just below all ones, and then running a few cycles. It repeats this with a nonzero reload value to walk the postscaler through its countdown. Writes that land exactly on a tap edge check that a software load never produces a tap.

// File: rtl/cyccnt_sampler.sv
module cyccnt_sampler #(
  parameter int CNT_W  = 32,
  parameter int PC_W   = 32,
  parameter int PS_W   = 4,
  parameter int TAP_LO = 6,
  parameter int TAP_HI = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halted,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             sample_valid,
  output logic [PC_W-1:0]  sample_pc,
  output logic             event_pulse
);
  localparam int CTRL_W = 4 + PS_W;

  logic [CNT_W-1:0] count;
  logic [PS_W-1:0]  reload, ps;
  logic             cnt_en, pcs_en, evt_en, tap_sel;

  wire              cnt_wr  = reg_wr && !reg_addr;
  wire              ctrl_wr = reg_wr && reg_addr;
  wire              inc     = cnt_en && !halted && !cnt_wr;
  wire [CNT_W-1:0]  count_p1 = count + 1'b1;
  wire              flip    = tap_sel ? (count_p1[TAP_HI] ^ count[TAP_HI])
                                      : (count_p1[TAP_LO] ^ count[TAP_LO]);
  wire              tap     = inc && flip;
  wire              fire    = tap && (ps == '0);

  assign reg_rdata = reg_addr
    ? {{(CNT_W-CTRL_W){1'b0}}, reload, tap_sel, evt_en, pcs_en, cnt_en}
    : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      {reload, tap_sel, evt_en, pcs_en, cnt_en} <= '0;
      ps <= '0;
      sample_valid <= 1'b0;
      event_pulse <= 1'b0;
      sample_pc <= '0;
    end else begin
      if (cnt_wr) count <= reg_wdata;
      else if (inc) count <= count_p1;

      if (ctrl_wr) begin
        {reload, tap_sel, evt_en, pcs_en, cnt_en} <= reg_wdata[CTRL_W-1:0];
        ps <= reg_wdata[CTRL_W-1:4];
      end else if (tap) begin
        ps <= fire ? reload : ps - 1'b1;
      end

      sample_valid <= fire && pcs_en;
      event_pulse  <= fire && !pcs_en && evt_en;
      if (fire && pcs_en) sample_pc <= pc_in;
    end
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !halted && !reg_wr) |=> (count == $past(count) + 1'b1));

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !reg_wr) |=> $stable(count));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !halted && !reg_wr && count == '1) |=> (count == '0));

  assert_sw_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> (count == $past(reg_wdata)));

  assert_one_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_valid && event_pulse));

  assert_no_enable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcs_en && !evt_en && !reg_wr) |=> (!sample_valid && !event_pulse));
endmodule

// File: tb/cyccnt_sampler_tb_top.sv
module cyccnt_sampler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halted = 1'b0;
  logic [31:0] pc_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sample_valid;
  logic [31:0] sample_pc;
  logic        event_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyccnt_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .halted(halted), .pc_in(pc_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sample_valid(sample_valid),
    .sample_pc(sample_pc), .event_pulse(event_pulse)
  );

  typedef struct {
    logic        sv;
    logic        ev;
    logic [31:0] pc;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  string cur_tag = "R11";

  logic [31:0] m_cnt = '0;
  logic [7:0]  m_ctrl = '0;
  logic [3:0]  m_ps = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic addr, input logic [31:0] wd,
                     input logic halt, input logic [31:0] pc);
    exp_t e;
    logic inc, tap, fire;
    logic [31:0] nxt;
    int tb;
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd; halted = halt; pc_in = pc;
    tb  = m_ctrl[3] ? 10 : 6;
    nxt = m_cnt + 1;
    inc = m_ctrl[0] && !halt && !(wr && !addr);
    tap = inc && (nxt[tb] != m_cnt[tb]);
    fire = tap && (m_ps == 0);
    e.sv  = fire && m_ctrl[1];
    e.ev  = fire && !m_ctrl[1] && m_ctrl[2];
    e.pc  = pc;
    e.tag = cur_tag;
    if (wr && !addr) m_cnt = wd;
    else if (inc) m_cnt = nxt;
    if (wr && addr) begin
      m_ctrl = wd[7:0];
      m_ps = wd[7:4];
    end else if (tap) begin
      m_ps = fire ? m_ctrl[7:4] : m_ps - 4'd1;
    end
    e.rd = addr ? {24'b0, m_ctrl} : m_cnt;
    q.push_back(e);
  endtask

  task automatic run(input int n, input logic addr);
    for (int i = 0; i < n; i++) cyc(1'b0, addr, '0, 1'b0, 32'h0000_1000 + i);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, {31'b0, sample_valid}, {31'b0, e.sv}, "sample_valid");
        check(e.tag, {31'b0, event_pulse}, {31'b0, e.ev}, "event_pulse");
        if (e.sv) check(e.tag, sample_pc, e.pc, "sample_pc");
        check(e.tag, reg_rdata, e.rd, "reg_rdata");
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    #(CLK_PERIOD * 3 + 2);
    check("R11", reg_rdata, 32'h0, "count in reset");
    check("R11", {30'b0, sample_valid, event_pulse}, 32'h0, "pulses in reset");
    @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R11"; run(2, 1'b1); run(2, 1'b0);
    cur_tag = "R5";  cyc(1'b1, 1'b1, 32'hABCD_0005, 1'b0, '0); run(1, 1'b1);
    cur_tag = "R1";  run(10, 1'b0);
    cur_tag = "R2";  for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, '0, 1'b1, '0);
    cur_tag = "R3";  cyc(1'b1, 1'b0, 32'hFFFF_FFFE, 1'b0, '0); run(4, 1'b0);
    cur_tag = "R6";  cyc(1'b1, 1'b0, 32'h0000_003E, 1'b0, '0); run(3, 1'b0);
    cyc(1'b1, 1'b0, 32'h0000_007E, 1'b0, '0); run(3, 1'b0);
    cur_tag = "R4";  cyc(1'b1, 1'b0, 32'h0000_003F, 1'b0, '0);
    cyc(1'b1, 1'b0, 32'h0000_0040, 1'b0, '0); run(2, 1'b0);
    cur_tag = "R7";  cyc(1'b1, 1'b1, 32'h0000_0025, 1'b0, '0);
    for (int k = 0; k < 5; k++) begin
      cyc(1'b1, 1'b0, 32'h0000_003E + (k << 6), 1'b0, '0); run(3, 1'b0);
    end
    cur_tag = "R8";  cyc(1'b1, 1'b1, 32'h0000_0007, 1'b0, '0);
    cyc(1'b1, 1'b0, 32'h0000_00BE, 1'b0, '0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, '0, 1'b0, 32'hCAFE_0000 + i);
    cur_tag = "R9";  cyc(1'b1, 1'b1, 32'h0000_0005, 1'b0, '0);
    cyc(1'b1, 1'b0, 32'h0000_013E, 1'b0, '0); run(3, 1'b0);
    cur_tag = "R10"; cyc(1'b1, 1'b1, 32'h0000_0001, 1'b0, '0);
    cyc(1'b1, 1'b0, 32'h0000_00FE, 1'b0, '0); run(3, 1'b0);
    cur_tag = "R6";  cyc(1'b1, 1'b1, 32'h0000_000D, 1'b0, '0);
    cyc(1'b1, 1'b0, 32'h0000_043E, 1'b0, '0); run(3, 1'b0);
    cyc(1'b1, 1'b0, 32'h0000_03FE, 1'b0, '0); run(3, 1'b0);
    cyc(1'b1, 1'b0, 32'h0000_07FE, 1'b0, '0); run(3, 1'b0);
    cur_tag = "R3";  cyc(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, '0); run(2, 1'b0);
    @(posedge clk);
    #2;
    check("R11", q.size(), 0, "scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule